// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between the command decoder of a boot-block flash array and its program/erase engine. For each program or erase request it decides, in one registered step, whether the targeted block may be modified. The array holds 74 blocks: 62 main blocks, 4 large parameter blocks and 8 small parameter blocks. A boot strap says whether the parameter blocks sit at the high or the low end of the address space.

Four independent protections are combined:
- a device reset pin, which blocks everything;
- a program-enable input, which also blocks everything;
- a write-protect pin, which makes a volatile per-block protection mask take effect;
- a 64-bit password lock, which covers every block except one fixed pair.

The password lives in a one-time-programmable store that is modelled as a register whose bits can only be cleared. The password lock can be removed entirely by a build parameter that stands for a factory option.

Denied requests, failed unlocks and refused password writes each set a sticky status bit. A clear-status command clears these bits.

Top module: `flash_guard`

## Requirements
- R1: One cycle after a cycle with `req_valid`=1, `grant_valid` is 1 and `grant` is 1 only if every protection condition is met. After a cycle without a request, `grant_valid` and `grant` are 0.
- R2: While `rp_n`=0, the following hold:
  - every request is denied;
  - the three error bits are cleared;
  - every per-block protection bit is set;
  - the password lock is engaged;
  - configuration, unlock and password commands have no effect.
- R3: While `pen`=0, every request is denied.
- R4: While `wp_n`=0, a request to a block whose protection bit is 1 is denied. While `wp_n`=1, the protection bits have no effect on the decision.
- R5: All protection bits are 1 after power-up reset. `cfg_set` sets bit `cfg_blk` and `cfg_clr` clears it; set wins if both are given, and an index of 74 or more is ignored.
- R6: While the password lock is engaged, every block is denied except blocks 12 and 13 when `top_boot`=0, and blocks 60 and 61 when `top_boot`=1.
- R7: The password lock is engaged after power-up reset and after any `rp_n`=0 cycle. An unlock whose code equals the stored code releases the lock. Any other unlock engages the lock and sets `err_unlock`.
- R8: The stored code is all ones after power-up reset and is not changed by `rp_n`. A password write while the lock is released ANDs `pw_data` into the stored code. A password write while the lock is engaged leaves the code unchanged and sets `err_pwprog`.
- R9: Once the stored code is all zeros, every password write is refused and sets `err_pwprog`.
- R10: A denied request sets `err_prot`. A request to a block index of 74 or more is always denied.
- R11: The error bits are sticky until `clr_status`. An error event in the same cycle as `clr_status` leaves its bit set.
- R12: With `HAS_LOCK`=0, the following hold:
  - `tuning_locked` stays 0;
  - the password lock never denies a request;
  - unlock and password commands have no effect and set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| rp_n | input | 1 | Device reset pin, active low |
| wp_n | input | 1 | Write-protect pin, low enables the per-block mask |
| pen | input | 1 | Program-enable input, high allows modification |
| top_boot | input | 1 | 1 when the parameter blocks are at the high end |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | IDXW | Target block index |
| cfg_set | input | 1 | Set protection bit of `cfg_blk` |
| cfg_clr | input | 1 | Clear protection bit of `cfg_blk` |
| cfg_blk | input | IDXW | Block index for the protection commands |
| unlock_valid | input | 1 | Unlock command strobe |
| unlock_code | input | CODEW | Password offered |
| pwprog_valid | input | 1 | Password write strobe |
| pw_data | input | CODEW | Value ANDed into the stored code |
| clr_status | input | 1 | Clear the sticky error bits |
| grant_valid | output | 1 | Decision valid, one cycle after the request |
| grant | output | 1 | Request allowed |
| err_prot | output | 1 | Sticky: a request was denied |
| err_unlock | output | 1 | Sticky: an unlock failed |
| err_pwprog | output | 1 | Sticky: a password write was refused |
| tuning_locked | output | 1 | Password lock engaged |

## Verification
Every result is registered. The decision, the error bits, the lock status and a changed stored code are all visible one clock after the cycle that carried the stimulus.

The bench drives a new input set each falling edge and steps a reference model over the same inputs. It then compares all outputs at the following falling edge, so every sample lands exactly one rising edge after its cause.

A stored-code change is seen through a later unlock one cycle later. A protection-mask change is seen through a later request with `wp_n` low, also one cycle later.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int NBLK     = 74,
  parameter int CODEW    = 64,
  parameter int EX_BOT   = 12,
  parameter int EX_TOP   = 60,
  parameter bit HAS_LOCK = 1'b1,
  localparam int IDXW    = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rp_n,
  input  logic             wp_n,
  input  logic             pen,
  input  logic             top_boot,
  input  logic             req_valid,
  input  logic [IDXW-1:0]  req_blk,
  input  logic             cfg_set,
  input  logic             cfg_clr,
  input  logic [IDXW-1:0]  cfg_blk,
  input  logic             unlock_valid,
  input  logic [CODEW-1:0] unlock_code,
  input  logic             pwprog_valid,
  input  logic [CODEW-1:0] pw_data,
  input  logic             clr_status,
  output logic             grant_valid,
  output logic             grant,
  output logic             err_prot,
  output logic             err_unlock,
  output logic             err_pwprog,
  output logic             tuning_locked
);
  localparam logic [IDXW-1:0] LAST  = IDXW'(NBLK - 1);
  localparam logic [IDXW-1:0] XB0   = IDXW'(EX_BOT);
  localparam logic [IDXW-1:0] XB1   = IDXW'(EX_BOT + 1);
  localparam logic [IDXW-1:0] XT0   = IDXW'(EX_TOP);
  localparam logic [IDXW-1:0] XT1   = IDXW'(EX_TOP + 1);

  logic [NBLK-1:0]  prot_q;
  logic [CODEW-1:0] pw_q;
  logic             lock_q;

  logic in_range, exempt, prot_hit, ok;
  logic pw_zero, ul_match, pw_ok;
  logic set_ep, set_eu, set_ew;

  assign in_range = req_blk <= LAST;
  assign exempt   = top_boot ? (req_blk == XT0 || req_blk == XT1)
                             : (req_blk == XB0 || req_blk == XB1);
  assign prot_hit = in_range ? prot_q[req_blk] : 1'b1;
  assign ok       = rp_n && pen && in_range && !(!wp_n && prot_hit)
                    && !(lock_q && !exempt);

  assign pw_zero  = pw_q == '0;
  assign ul_match = unlock_code == pw_q;
  assign pw_ok    = HAS_LOCK && pwprog_valid && !lock_q && !pw_zero;

  assign set_ep   = req_valid && !ok;
  assign set_eu   = HAS_LOCK && unlock_valid && !ul_match;
  assign set_ew   = HAS_LOCK && pwprog_valid && !pw_ok;

  assign tuning_locked = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant       <= 1'b0;
    end else begin
      grant_valid <= req_valid;
      grant       <= req_valid && ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '1;
    end else if (!rp_n) begin
      prot_q <= '1;
    end else if (cfg_blk <= LAST) begin
      if (cfg_set)      prot_q[cfg_blk] <= 1'b1;
      else if (cfg_clr) prot_q[cfg_blk] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= HAS_LOCK;
    end else if (!rp_n) begin
      lock_q <= HAS_LOCK;
    end else if (HAS_LOCK && unlock_valid) begin
      lock_q <= !ul_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pw_q <= '1;
    else if (rp_n && pw_ok)    pw_q <= pw_q & pw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !rp_n) begin
      err_prot   <= 1'b0;
      err_unlock <= 1'b0;
      err_pwprog <= 1'b0;
    end else begin
      err_prot   <= (err_prot   && !clr_status) || set_ep;
      err_unlock <= (err_unlock && !clr_status) || set_eu;
      err_pwprog <= (err_pwprog && !clr_status) || set_ew;
    end
  end

  a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> grant_valid);
  a_r1_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant_valid && !grant));
  a_r2_reset_pin_denies: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (!grant && !err_prot && !err_unlock && !err_pwprog));
  a_r3_enable_low_denies: assert property (@(posedge clk) disable iff (!rst_n)
    !pen |=> !grant);
  a_r7_bad_unlock_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_LOCK && rp_n && unlock_valid && unlock_code != pw_q) |=> (tuning_locked && err_unlock));
  a_r8_code_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pw_q & ~$past(pw_q)) == '0));
  a_r9_zero_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_n && pwprog_valid && pw_q == '0) |=> ($stable(pw_q) && (err_pwprog || !HAS_LOCK)));
  a_r6_lock_denies_nonexempt: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tuning_locked && !(top_boot ? (req_blk == XT0 || req_blk == XT1)
                                               : (req_blk == XB0 || req_blk == XB1))) |=> !grant);
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  localparam int NBLK = 74, CODEW = 64, IDXW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rp_n, wp_n, pen, top_boot, req_valid, cfg_set, cfg_clr;
  logic unlock_valid, pwprog_valid, clr_status;
  logic [IDXW-1:0] req_blk, cfg_blk;
  logic [CODEW-1:0] unlock_code, pw_data;
  logic grant_valid, grant, err_prot, err_unlock, err_pwprog, tuning_locked;
  logic nt_gv, nt_g, nt_ep, nt_eu, nt_ew, nt_lock;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  flash_guard u_flash_guard (
    .clk, .rst_n, .rp_n, .wp_n, .pen, .top_boot, .req_valid, .req_blk,
    .cfg_set, .cfg_clr, .cfg_blk, .unlock_valid, .unlock_code,
    .pwprog_valid, .pw_data, .clr_status, .grant_valid, .grant,
    .err_prot, .err_unlock, .err_pwprog, .tuning_locked);

  flash_guard #(.HAS_LOCK(1'b0)) u_flash_guard_nolock (
    .clk, .rst_n, .rp_n, .wp_n, .pen, .top_boot, .req_valid, .req_blk,
    .cfg_set, .cfg_clr, .cfg_blk, .unlock_valid, .unlock_code,
    .pwprog_valid, .pw_data, .clr_status, .grant_valid(nt_gv), .grant(nt_g),
    .err_prot(nt_ep), .err_unlock(nt_eu), .err_pwprog(nt_ew), .tuning_locked(nt_lock));

  logic [NBLK-1:0] m_prot;
  logic [CODEW-1:0] m_pw;
  logic m_lock, m_ep, m_eu, m_ew, m_gv, m_g, m_gnt_nt;

  function automatic bit calc_ok(input bit lock);
    bit inr, ex, ph;
    inr = req_blk < IDXW'(NBLK);
    ex  = top_boot ? (req_blk == 7'd60 || req_blk == 7'd61)
                   : (req_blk == 7'd12 || req_blk == 7'd13);
    ph  = inr ? m_prot[req_blk] : 1'b1;
    return rp_n && pen && inr && !(!wp_n && ph) && !(lock && !ex);
  endfunction

  task automatic model_step();
    bit ok, okn, pwok, sp, su, sw;
    if (!rp_n) begin
      m_gv = req_valid; m_g = 0; m_gnt_nt = 0;
      m_prot = '1; m_lock = 1; m_ep = 0; m_eu = 0; m_ew = 0;
    end else begin
      ok = calc_ok(m_lock); okn = calc_ok(1'b0);
      m_gv = req_valid; m_g = req_valid && ok; m_gnt_nt = req_valid && okn;
      sp = req_valid && !ok;
      su = unlock_valid && (unlock_code != m_pw);
      pwok = pwprog_valid && !m_lock && (m_pw != '0);
      sw = pwprog_valid && !pwok;
      if (unlock_valid) m_lock = (unlock_code != m_pw);
      if (pwok) m_pw = m_pw & pw_data;
      if (cfg_blk < IDXW'(NBLK)) begin
        if (cfg_set) m_prot[cfg_blk] = 1'b1;
        else if (cfg_clr) m_prot[cfg_blk] = 1'b0;
      end
      m_ep = (m_ep && !clr_status) || sp;
      m_eu = (m_eu && !clr_status) || su;
      m_ew = (m_ew && !clr_status) || sw;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "grant_valid", grant_valid, m_gv);
    chk(tag, "grant", grant, m_g);
    chk(tag, "err_prot", err_prot, m_ep);
    chk(tag, "err_unlock", err_unlock, m_eu);
    chk(tag, "err_pwprog", err_pwprog, m_ew);
    chk(tag, "tuning_locked", tuning_locked, m_lock);
    chk("R12", "nolock grant", nt_g, m_gnt_nt);
    chk("R12", "nolock tuning_locked", nt_lock, 1'b0);
    chk("R12", "nolock err_unlock", nt_eu, 1'b0);
    chk("R12", "nolock err_pwprog", nt_ew, 1'b0);
  endtask

  task automatic idle();
    req_valid = 0; cfg_set = 0; cfg_clr = 0; unlock_valid = 0;
    pwprog_valid = 0; clr_status = 0; req_blk = '0; cfg_blk = '0;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk); @(negedge clk);
    check_all(tag);
    idle();
  endtask

  task automatic req(input int blk, input string tag);
    req_valid = 1; req_blk = IDXW'(blk); tick(tag);
  endtask

  task automatic unlock(input logic [CODEW-1:0] c, input string tag);
    unlock_valid = 1; unlock_code = c; tick(tag);
  endtask

  task automatic pwprog(input logic [CODEW-1:0] d, input string tag);
    pwprog_valid = 1; pw_data = d; tick(tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rp_n = 1; wp_n = 1; pen = 1; top_boot = 0;
    unlock_code = '0; pw_data = '1; idle();
    m_prot = '1; m_pw = '1; m_lock = 1;
    m_ep = 0; m_eu = 0; m_ew = 0; m_gv = 0; m_g = 0; m_gnt_nt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R7");

    req(12, "R6"); req(13, "R6");
    req(5, "R6");
    chk("R10", "err_prot after deny", err_prot, 1'b1);
    clr_status = 1; tick("R11");
    clr_status = 1; req_valid = 1; req_blk = 7'd4; tick("R11");
    clr_status = 1; tick("R11");

    unlock(64'h1234, "R7");
    pwprog(64'h0, "R8");
    clr_status = 1; tick("R11");
    unlock('1, "R7");
    req(5, "R1");
    wp_n = 0; req(5, "R5");
    cfg_clr = 1; cfg_blk = 7'd5; tick("R5");
    req(5, "R4"); req(6, "R4");
    cfg_set = 1; cfg_clr = 1; cfg_blk = 7'd5; tick("R5");
    req(5, "R5");
    wp_n = 1; req(6, "R4");
    pen = 0; req(6, "R3"); pen = 1;
    req(74, "R10"); req(127, "R10");
    cfg_clr = 1; cfg_blk = 7'd100; tick("R5");

    top_boot = 1; unlock(64'h5, "R7");
    req(60, "R6"); req(61, "R6"); req(12, "R6");
    top_boot = 0; req(61, "R6");
    unlock('1, "R7");
    pwprog({{48{1'b1}}, 16'h0}, "R8");
    unlock('1, "R8");
    unlock({{48{1'b1}}, 16'h0}, "R8");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rp_n = r != 0;
      wp_n = $urandom_range(0, 1) != 0;
      pen = $urandom_range(0, 9) != 0;
      top_boot = $urandom_range(0, 1) != 0;
      req_valid = $urandom_range(0, 2) != 0;
      req_blk = IDXW'($urandom_range(0, 79));
      cfg_blk = IDXW'($urandom_range(0, 76));
      cfg_set = $urandom_range(0, 7) == 0;
      cfg_clr = $urandom_range(0, 3) == 0;
      unlock_valid = $urandom_range(0, 9) == 0;
      unlock_code = ($urandom_range(0, 1) != 0) ? m_pw : {$urandom, $urandom};
      pwprog_valid = $urandom_range(0, 15) == 0;
      pw_data = ~(64'h1 << $urandom_range(0, 63));
      clr_status = $urandom_range(0, 7) == 0;
      tick("R1");
    end

    rp_n = 1; pen = 1; wp_n = 1; top_boot = 0;
    unlock(m_pw, "R7");
    pwprog('0, "R8");
    unlock('0, "R9");
    pwprog(64'hF0, "R9");
    chk("R9", "err_pwprog on zero code", err_pwprog, 1'b1);
    unlock('0, "R9");

    rp_n = 0; req_valid = 1; req_blk = 7'd12; unlock_valid = 1; unlock_code = '0;
    cfg_clr = 1; cfg_blk = 7'd3; tick("R2");
    rp_n = 1;
    chk("R2", "relocked", tuning_locked, 1'b1);
    unlock('0, "R8");
    wp_n = 0; req(3, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule